// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block turns two digital health signals into the processor reset. One input is a supply-good flag, already compared and aligned to the clock elsewhere. The other is an active-low manual-reset pin. Reset is raised as soon as either cause appears. Once every cause has cleared, reset stays up for a fixed number of clock cycles before it is released. Any new cause that appears during that wait sends the block back to holding, and the wait then starts again from zero.

The manual-reset pin is asynchronous. It passes through a two-flop synchronizer and then a width qualifier, which drops low pulses shorter than a set number of cycles. The reset is driven at both polarities. A reset-active status copy goes to the other supervisory blocks. A one-cycle release strobe marks the first cycle in which reset is no longer asserted.

The controller is a four-state machine:
- **HOLD**: at least one cause is present.
- **TIMING**: the timeout counter is running.
- **RELEASE**: the single strobe cycle.
- **RUN**: normal operation.

The transitions are:
- HOLD→TIMING when no cause is present.
- TIMING→HOLD on any cause.
- TIMING→RELEASE when the counter reaches its last count.
- RELEASE→RUN when no cause is present.
- RELEASE→HOLD and RUN→HOLD on any cause.

The block leaves its own reset in HOLD.

Top module: `sup_reset_gen`

## Requirements
- R1: When supply_ok is sampled low at a clock edge, rst_out_n is 0 in the cycle that follows that edge. It stays 0 for as long as supply_ok stays low.
- R2: supply_ok may return high with the manual-reset input idle. Counting from the first edge that samples it high, rst_out_n stays 0 for exactly TIMEOUT_CYCLES cycles and then goes to 1.
- R3: supply_ok may drop low for even one edge while the timeout is running. The count then restarts, and release comes TIMEOUT_CYCLES cycles after the edge at which supply_ok is high again.
- R4: mr_n may be held low for at least MR_MIN_CYCLES cycles. Reset is then asserted and held for as long as mr_n stays low. Reset is released TIMEOUT_CYCLES+3 cycles after the first edge that samples mr_n high. The three extra cycles are two synchronizer stages and one qualifier register.
- R5: rst_out is always the inverse of rst_out_n, and rst_active always equals rst_out.
- R6: A low pulse on mr_n that lasts MR_MIN_CYCLES-1 clock cycles is ignored. rst_out_n stays 1 throughout. A pulse of exactly MR_MIN_CYCLES cycles asserts reset.
- R7: While rst_n is low, rst_out_n is 0 and release_pulse is 0. If supply_ok is high when rst_n is released, a full timeout runs: TIMEOUT_CYCLES cycles counted from the first edge after release.
- R8: release_pulse is 1 for exactly one cycle. That cycle is the first one in which rst_out_n is 1 after being 0.
- R9: A qualified manual-reset assertion during the timeout restarts the count. Release then follows TIMEOUT_CYCLES+3 cycles after mr_n returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's own registers |
| supply_ok | input | 1 | Synchronous flag, high while the supply is above the reset threshold |
| mr_n | input | 1 | Asynchronous active-low manual-reset request |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| rst_active | output | 1 | Reset-active status for other supervisory blocks |
| release_pulse | output | 1 | One-cycle strobe on the first released cycle |

## Verification
The assertions assume that supply_ok is already synchronous to clk. They also assume that mr_n only changes far enough from an edge for the synchronizer to resolve within one cycle. The manual-reset window check further assumes that a mr_n low run outlasts the synchronizer and qualifier latency before the property fires. The stimulus changes every input on the falling edge only, and holds each manual-reset level for whole clock cycles. The exact cycle counts of R2, R4 and R9 therefore hold with no metastability slack.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_RUN     = 2'd3
    } rst_state_t;

endpackage

// File: rtl/sup_mr_sync.sv
module sup_mr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // First stage samples the pin; later stages follow the one before.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else        chain_q[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/sup_mr_qualify.sv
module sup_mr_qualify #(
    parameter int unsigned MIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_sync_n,
    output logic mr_req
);

    localparam int unsigned CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYCLES);

    logic [CW-1:0] low_cnt_q;

    // Count consecutive low samples; saturate at the limit; clear on high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (mr_sync_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != LIMIT) begin
            low_cnt_q <= low_cnt_q + CW'(1);
        end
    end

    assign mr_req = (low_cnt_q == LIMIT);

endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
    parameter int unsigned CYCLES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Clear wins; counting stops at the last value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
    import sup_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic tmr_done,
    output logic tmr_clr,
    output logic tmr_run,
    output logic rst_asserted,
    output logic strobe
);

    rst_state_t state_q;
    rst_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!cause) state_d = ST_TIMING;
            ST_TIMING:  if (cause) state_d = ST_HOLD;
                        else if (tmr_done) state_d = ST_RELEASE;
            ST_RELEASE: state_d = cause ? ST_HOLD : ST_RUN;
            ST_RUN:     if (cause) state_d = ST_HOLD;
            default:    state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        tmr_clr      = 1'b1;
        tmr_run      = 1'b0;
        rst_asserted = 1'b1;
        strobe       = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                tmr_clr = 1'b1;
            end
            ST_TIMING: begin
                tmr_clr = 1'b0;
                tmr_run = 1'b1;
            end
            ST_RELEASE: begin
                rst_asserted = 1'b0;
                strobe       = 1'b1;
            end
            ST_RUN: begin
                rst_asserted = 1'b0;
            end
            default: begin
                rst_asserted = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int unsigned TIMEOUT_CYCLES = 1600,
    parameter int unsigned MR_MIN_CYCLES  = 4,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mr_n,
    output logic rst_out_n,
    output logic rst_out,
    output logic rst_active,
    output logic release_pulse
);

    logic mr_sync_n;
    logic mr_req;
    logic cause;
    logic tmr_clr;
    logic tmr_run;
    logic tmr_done;
    logic rst_asserted;

    sup_mr_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mr_n),
        .sync_out (mr_sync_n)
    );

    sup_mr_qualify #(.MIN_CYCLES(MR_MIN_CYCLES)) i_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_sync_n (mr_sync_n),
        .mr_req    (mr_req)
    );

    assign cause = !supply_ok || mr_req;

    sup_rst_timer #(.CYCLES(TIMEOUT_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    sup_rst_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cause        (cause),
        .tmr_done     (tmr_done),
        .tmr_clr      (tmr_clr),
        .tmr_run      (tmr_run),
        .rst_asserted (rst_asserted),
        .strobe       (strobe_w)
    );

    logic strobe_w;

    assign rst_out_n     = !rst_asserted;
    assign rst_out       = rst_asserted;
    assign rst_active    = rst_asserted;
    assign release_pulse = strobe_w;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 1600,
    parameter int unsigned MR_MIN_CYCLES  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic mr_n,
    input logic rst_out_n,
    input logic rst_out,
    input logic rst_active,
    input logic release_pulse
);

    localparam int unsigned OKW = $clog2(TIMEOUT_CYCLES + 2);
    localparam int unsigned MR_LAT = MR_MIN_CYCLES + 3;
    localparam int unsigned MRW = $clog2(MR_LAT + 1);

    logic [OKW-1:0] ok_cnt_q;
    logic [MRW-1:0] mr_lo_q;

    // Consecutive edges with supply_ok high, saturating at the timeout.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               ok_cnt_q <= '0;
        else if (!supply_ok)                      ok_cnt_q <= '0;
        else if (ok_cnt_q != OKW'(TIMEOUT_CYCLES)) ok_cnt_q <= ok_cnt_q + OKW'(1);
    end

    // Consecutive edges with mr_n low, saturating at the path latency.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        mr_lo_q <= '0;
        else if (mr_n)                     mr_lo_q <= '0;
        else if (mr_lo_q != MRW'(MR_LAT))  mr_lo_q <= mr_lo_q + MRW'(1);
    end

    a_r1_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !rst_out_n);

    a_r2_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (ok_cnt_q >= OKW'(TIMEOUT_CYCLES)));

    a_r4_mr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_lo_q == MRW'(MR_LAT)) |-> !rst_out_n);

    a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out == !rst_out_n) && (rst_active == rst_out));

    a_r8_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> $rose(rst_out_n));

    a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> release_pulse);

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse);

endmodule

bind sup_reset_gen sup_reset_gen_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .MR_MIN_CYCLES  (MR_MIN_CYCLES)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .mr_n          (mr_n),
    .rst_out_n     (rst_out_n),
    .rst_out       (rst_out),
    .rst_active    (rst_active),
    .release_pulse (release_pulse)
);

// File: tb/test_sup_reset_gen.sv
module test_sup_reset_gen;

    localparam int unsigned T   = 40;
    localparam int unsigned MIN = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic supply_ok;
    logic mr_n;
    logic rst_out_n;
    logic rst_out;
    logic rst_active;
    logic release_pulse;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sup_reset_gen #(
        .TIMEOUT_CYCLES (T),
        .MR_MIN_CYCLES  (MIN)
    ) i_sup_reset_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok     (supply_ok),
        .mr_n          (mr_n),
        .rst_out_n     (rst_out_n),
        .rst_out       (rst_out),
        .rst_active    (rst_active),
        .release_pulse (release_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts the falling-edge samples with reset asserted, then checks the strobe.
    task automatic measure_hold(input string req, input int exp);
        int n;
        n = 0;
        @(negedge clk);
        while (!rst_out_n && n < 5000) begin
            n++;
            @(negedge clk);
        end
        chk(req, n, exp);
        chk("R8 strobe on first released cycle", int'(release_pulse), 1);
        chk("R5 polarity", int'(rst_out), int'(!rst_out_n));
        @(negedge clk);
        chk("R8 strobe single cycle", int'(release_pulse), 0);
    endtask

    task automatic t_powerup();
        rst_n = 1'b0; supply_ok = 1'b1; mr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 reset out_n during block reset", int'(rst_out_n), 0);
        chk("R7 strobe low during block reset", int'(release_pulse), 0);
        chk("R5 active-high copy", int'(rst_out), 1);
        chk("R5 status copy", int'(rst_active), 1);
        rst_n = 1'b1;
        measure_hold("R7 power-up timeout", T);
    endtask

    task automatic t_supply_drop();
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R1 assert after supply drop", int'(rst_out_n), 0);
        repeat (10) @(negedge clk);
        chk("R1 held while supply low", int'(rst_out_n), 0);
        supply_ok = 1'b1;
        measure_hold("R2 supply release timeout", T);
    endtask

    task automatic t_dip_restart();
        int seen_hi;
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        seen_hi = 0;
        repeat (T / 2) begin
            @(negedge clk);
            if (rst_out_n) seen_hi = 1;
        end
        chk("R3 still asserted mid-timeout", seen_hi, 0);
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        measure_hold("R3 restart after dip", T);
    endtask

    task automatic t_mr_hold();
        mr_n = 1'b0;
        repeat (100) @(negedge clk);
        chk("R4 held while manual reset low", int'(rst_out_n), 0);
        mr_n = 1'b1;
        measure_hold("R4 manual release timeout", T + 3);
    endtask

    task automatic t_mr_glitch();
        int seen_lo;
        mr_n = 1'b0;
        repeat (MIN - 1) @(negedge clk);
        mr_n = 1'b1;
        seen_lo = 0;
        repeat (30) begin
            @(negedge clk);
            if (!rst_out_n) seen_lo = 1;
        end
        chk("R6 short pulse ignored", seen_lo, 0);
        mr_n = 1'b0;
        repeat (MIN) @(negedge clk);
        mr_n = 1'b1;
        seen_lo = 0;
        repeat (10) begin
            @(negedge clk);
            if (!rst_out_n) seen_lo = 1;
        end
        chk("R6 minimum pulse accepted", seen_lo, 1);
        repeat (T + 10) @(negedge clk);
        chk("R6 released after accepted pulse", int'(rst_out_n), 1);
    endtask

    task automatic t_mr_restart();
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (T / 2) @(negedge clk);
        mr_n = 1'b0;
        repeat (MIN + 2) @(negedge clk);
        chk("R9 asserted during manual restart", int'(rst_out_n), 0);
        mr_n = 1'b1;
        measure_hold("R9 restart by manual reset", T + 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; mr_n = 1'b1;
        @(negedge clk);
        t_powerup();
        t_supply_drop();
        t_dip_restart();
        t_mr_hold();
        t_mr_glitch();
        t_mr_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule